// File: doc/BRIEF.md
# Sigma-Delta Decimator with Result Register

This block takes the one-bit output of a second-order sigma-delta modulator and turns it into 16-bit conversion results. A third-order cascaded integrator-comb filter runs on every modulator sample. It decimates by a ratio chosen at run time, from 32 to 1024. Each decimated value is scaled to a 16-bit range and encoded in one of three number formats. The encoded value is written to a result register, which raises a flag and the interrupt line.

The modulator rate is presented as a one-cycle sample enable, `mod_tick`, in the system clock domain. A small register port carries three things. Address 0 holds the control word and starts or stops conversions. Address 1 holds the busy and flag status. Address 2 holds the result. Reading the result clears the flag, and software can also clear the flag through the status address.

A conversion is either single or continuous. Filter outputs are not used until the filter has settled. A single conversion gives one result and then goes idle. A continuous conversion gives a result at every decimation step until it is stopped.

Top module: `sdd_decim`

## Requirements
- R1: After reset, busy, flag, `irq`, the latched configuration and the result are all zero.
- R2: Control bits [5:3] select the oversampling ratio. Codes 0 to 5 select 32·2^code, and codes 6 and 7 select 1024. The configuration (control bits [7:2]) is captured only by a control write with bit 0 (start) set. A single conversion finishes on exactly the 3·ratio-th accepted sample after start.
- R3: The filter is a third-order integrator-comb sinc filter. Its output v is scaled to n = v·65536/ratio³. For a periodic stream whose period divides 32 and whose ones-density is d, n = 65536·d.
- R4: Control bits [7:6] select the format. Code 0 is offset binary, min(n, 0xFFFF). Code 1 is two's complement, the offset-binary value XOR 0x8000. Code 2 is unipolar: 0 when n ≤ 0x8000, otherwise min(2·(n−0x8000), 0xFFFF). Code 3 behaves as code 0.
- R5: The first two decimation outputs after a start are discarded. The first result is written at the third decimation step.
- R6: In single mode (control bit 2 = 0) exactly one result is written. Busy clears on the same edge that writes it.
- R7: In continuous mode (control bit 2 = 1) a result is written every ratio samples after the first. A control write with bit 1 (stop) set clears busy, and no further result is written.
- R8: The flag sets whenever a new result is written. The result register holds its value otherwise. `irq` follows the flag.
- R9: A read of address 2 clears the flag, and so does a write to address 1 with bit 1 set. A new result in the same cycle as a clear leaves the flag set.
- R10: While busy, start requests and configuration values are ignored. The readback at address 0 and the busy status do not change.
- R11: The filter advances only on cycles with `mod_tick` high. Idle cycles between samples do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_tick | input | 1 | Modulator sample enable, one cycle per sample |
| mod_bit | input | 1 | Modulator output bit, valid with `mod_tick` |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 result |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Result-ready interrupt, equal to the flag |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a new result. The stimulus runs a continuous conversion with the sample count tracked in the bench, then issues the status-clear write on the very sample that completes the next decimation period. Settling and scaling are checked with periodic streams whose ones-density gives exact expected codes at every ratio. The arrival sample of every result is compared with the count expected from the ratio, so an early unsettled output or a wrong ratio decode shows up as a timing mismatch.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    localparam int RES_W    = 16;
    localparam int CIC_N    = 3;
    localparam int MIN_LOG2 = 5;
    localparam int MAX_LOG2 = 10;
    localparam int ACC_W    = 1 + CIC_N * MAX_LOG2;
    localparam int CODE_W   = 3;
    localparam int LOG_W    = 4;
    localparam int SKIP_N   = CIC_N - 1;

    typedef enum logic [1:0] {
        FMT_OFFSET = 2'd0,
        FMT_TWOS   = 2'd1,
        FMT_UNI    = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    // packs into control bits [7:2]: fmt [7:6], ratio code [5:3], continuous [2]
    typedef struct packed {
        fmt_e              fmt;
        logic [CODE_W-1:0] osr_code;
        logic              cont;
    } cfg_t;

    typedef logic [ACC_W-1:0] acc_t;

    function automatic logic [LOG_W-1:0] code_to_log2(logic [CODE_W-1:0] c);
        int l;
        l = MIN_LOG2 + int'(c);
        if (l > MAX_LOG2) l = MAX_LOG2;
        return LOG_W'(l);
    endfunction

    // maps v in [0, 2^(CIC_N*l2)] onto [0, 2^RES_W]
    function automatic logic [RES_W:0] scale_to_unit(acc_t v, logic [LOG_W-1:0] l2);
        int sh;
        sh = CIC_N * int'(l2) - (RES_W - 1);
        return (RES_W+1)'({v, 1'b0} >> sh);
    endfunction

    function automatic logic [RES_W-1:0] apply_format(logic [RES_W:0] n, fmt_e f);
        logic [RES_W-1:0] ob;
        logic [RES_W-1:0] uni;
        logic [RES_W:0]   mid;
        logic [RES_W:0]   ex;
        mid = {2'b01, {(RES_W-1){1'b0}}};
        ob  = n[RES_W] ? '1 : n[RES_W-1:0];
        if (n <= mid) begin
            uni = '0;
        end else begin
            ex  = (n - mid) << 1;
            uni = ex[RES_W] ? '1 : ex[RES_W-1:0];
        end
        case (f)
            FMT_TWOS: return ob ^ {1'b1, {(RES_W-1){1'b0}}};
            FMT_UNI:  return uni;
            default:  return ob;
        endcase
    endfunction

endpackage

// File: rtl/sdd_cic3.sv
module sdd_cic3
    import sdd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             bit_in,
    input  logic [LOG_W-1:0] l2,
    output logic             dec_stb,
    output acc_t             dec_val
);

    acc_t integ [CIC_N];
    acc_t dly   [CIC_N];
    acc_t i_nx  [CIC_N];
    acc_t c_nx  [CIC_N];
    logic [MAX_LOG2-1:0] phase;
    logic                phase_last;

    always_comb begin
        i_nx[0] = integ[0] + acc_t'(bit_in);
        for (int k = 1; k < CIC_N; k++) i_nx[k] = integ[k] + i_nx[k-1];
        c_nx[0] = i_nx[CIC_N-1] - dly[0];
        for (int k = 1; k < CIC_N; k++) c_nx[k] = c_nx[k-1] - dly[k];
    end

    assign phase_last = (phase == MAX_LOG2'((1 << l2) - 1));
    assign dec_stb    = step && phase_last;
    assign dec_val    = c_nx[CIC_N-1];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= '0;
            for (int k = 0; k < CIC_N; k++) begin
                integ[k] <= '0;
                dly[k]   <= '0;
            end
        end else if (step) begin
            for (int k = 0; k < CIC_N; k++) integ[k] <= i_nx[k];
            phase <= phase_last ? '0 : phase + 1'b1;
            if (phase_last) begin
                dly[0] <= i_nx[CIC_N-1];
                for (int k = 1; k < CIC_N; k++) dly[k] <= c_nx[k-1];
            end
        end
    end

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(phase) < (1 << int'(l2)));

endmodule

// File: rtl/sdd_fmt.sv
module sdd_fmt
    import sdd_pkg::*;
(
    input  acc_t             raw,
    input  logic [LOG_W-1:0] l2,
    input  fmt_e             fmt,
    output logic [RES_W-1:0] word
);

    logic [RES_W:0] unit;

    always_comb begin
        unit = scale_to_unit(raw, l2);
        word = apply_format(unit, fmt);
    end

endmodule

// File: rtl/sdd_ctrl.sv
module sdd_ctrl
    import sdd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             stop_req,
    input  cfg_t             cfg_in,
    input  logic             dec_stb,
    input  logic [RES_W-1:0] fmt_word,
    input  logic             rd_result,
    input  logic             clr_flag,
    output logic             busy,
    output cfg_t             cfg,
    output logic             flag,
    output logic [RES_W-1:0] result,
    output logic             clear_core
);

    logic [1:0] seen;
    logic       accept_start;
    logic       pub;

    assign accept_start = start_req && !busy;
    assign clear_core   = accept_start;
    assign pub          = dec_stb && busy && !stop_req && (seen == 2'(SKIP_N));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cfg    <= '0;
            seen   <= '0;
            flag   <= 1'b0;
            result <= '0;
        end else begin
            if (accept_start) begin
                busy <= 1'b1;
                cfg  <= cfg_in;
                seen <= '0;
            end else if (busy) begin
                if (stop_req) begin
                    busy <= 1'b0;
                end else if (dec_stb) begin
                    if (seen != 2'(SKIP_N)) seen <= seen + 1'b1;
                    else if (!cfg.cont)     busy <= 1'b0;
                end
            end
            if (pub) result <= fmt_word;
            if (pub)                         flag <= 1'b1;
            else if (rd_result || clr_flag)  flag <= 1'b0;
        end
    end

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(pub));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pub |=> $stable(result));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_result && !pub) |=> !flag);

    // R6
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        (pub && !cfg.cont) |=> !busy);

    // R7
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_req && busy) |=> !busy);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));

endmodule

// File: rtl/sdd_decim.sv
module sdd_decim
    import sdd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_tick,
    input  logic             mod_bit,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [RES_W-1:0] reg_rdata,
    output logic             irq
);

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_RES  = 2'd2;

    logic             start_req, stop_req, rd_result, clr_flag;
    logic             busy, flag, clear_core, dec_stb;
    cfg_t             cfg;
    logic [RES_W-1:0] result, fmt_word;
    logic [LOG_W-1:0] l2;
    acc_t             dec_val;

    assign start_req = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
    assign stop_req  = reg_wr && (reg_addr == A_CTRL) && reg_wdata[1];
    assign clr_flag  = reg_wr && (reg_addr == A_STAT) && reg_wdata[1];
    assign rd_result = reg_rd && (reg_addr == A_RES);
    assign l2        = code_to_log2(cfg.osr_code);
    assign irq       = flag;

    sdd_cic3 u_cic (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear_core),
        .step    (mod_tick && busy),
        .bit_in  (mod_bit),
        .l2      (l2),
        .dec_stb (dec_stb),
        .dec_val (dec_val)
    );

    sdd_fmt u_fmt (
        .raw  (dec_val),
        .l2   (l2),
        .fmt  (cfg.fmt),
        .word (fmt_word)
    );

    sdd_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .cfg_in     (cfg_t'(reg_wdata[7:2])),
        .dec_stb    (dec_stb),
        .fmt_word   (fmt_word),
        .rd_result  (rd_result),
        .clr_flag   (clr_flag),
        .busy       (busy),
        .cfg        (cfg),
        .flag       (flag),
        .result     (result),
        .clear_core (clear_core)
    );

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {8'b0, cfg, 2'b00};
            A_STAT:  reg_rdata = {14'b0, flag, busy};
            A_RES:   reg_rdata = result;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/sdd_decim_test.sv
`timescale 1ns/1ps
module sdd_decim_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_tick = 1'b0, mod_bit = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    typedef struct { int val; int at; string tag; } exp_t;
    exp_t q[$];
    int   n_tests = 0, n_fail = 0, tcount = 0;
    bit   auto_read = 1'b1, finished = 1'b0;

    always #2 clk = ~clk;

    sdd_decim uut (.*);

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output int d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = int'(reg_rdata);
        @(negedge clk); reg_rd = 1'b0;
    endtask

    // monitor: on irq pop the scoreboard and compare value and arrival sample
    task automatic monitor();
        int v;
        exp_t e;
        if (auto_read && irq) begin
            bus_read(2'd2, v);
            if (q.size() == 0) begin
                chk("R6/R7 unexpected result", v, -1);
            end else begin
                e = q.pop_front();
                chk({e.tag, " value"}, v, e.val);
                chk({e.tag, " arrival sample (R2 R5)"}, tcount, e.at);
            end
        end
    endtask

    // R11: every sample is followed by idle cycles, extra ones every 7th
    task automatic tick(logic b, logic clr);
        @(negedge clk);
        mod_tick = 1'b1; mod_bit = b;
        if (clr) begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h02; end
        @(negedge clk);
        mod_tick = 1'b0; reg_wr = 1'b0;
        tcount++;
        if (tcount % 7 == 0) @(negedge clk);
        monitor();
    endtask

    task automatic run(int d, int p, int n);
        for (int i = 0; i < n; i++) tick(((tcount % p) < d), 1'b0);
    endtask

    task automatic start(int code, int fmt, bit cont);
        tcount = 0;
        bus_write(2'd0, {fmt[1:0], code[2:0], cont, 1'b0, 1'b1});
    endtask

    function automatic int ratio(int code);
        return (code >= 5) ? 1024 : (32 << code);
    endfunction

    function automatic int exp_val(int fmt, int d, int p);
        int n, ob;
        n  = (65536 * d) / p;
        ob = (n > 65535) ? 65535 : n;
        case (fmt)
            1: return ob ^ 32'h8000;
            2: return (n <= 32768) ? 0 : (((n - 32768) * 2 > 65535) ? 65535 : (n - 32768) * 2);
            default: return ob;
        endcase
    endfunction

    task automatic single(string tag, int code, int fmt, int d, int p);
        int s;
        exp_t e;
        e.val = exp_val(fmt, d, p); e.at = 3 * ratio(code); e.tag = tag;
        q.push_back(e);
        start(code, fmt, 1'b0);
        run(d, p, 3 * ratio(code) + 8);
        chk({tag, " scoreboard drained"}, q.size(), 0);
        bus_read(2'd1, s);
        chk({tag, " R6 idle after single"}, s, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        exp_t e;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        bus_read(2'd1, v); chk("R1 status", v, 0);
        bus_read(2'd0, v); chk("R1 config", v, 0);
        bus_read(2'd2, v); chk("R1 result", v, 0);

        // R2 R3 R4 R5 R6: single conversions across ratios and formats
        single("R3 R4 ones/32/offset",       0, 0, 1, 1);
        single("R3 R4 half/64/twos",         1, 1, 1, 2);
        single("R3 R4 3of4/128/unipolar",    2, 2, 3, 4);
        single("R3 R4 zeros/32/offset",      0, 0, 0, 1);
        single("R3 R4 zeros/32/twos",        0, 1, 0, 1);
        single("R3 R4 1of4/256/unipolar",    3, 2, 1, 4);
        single("R3 R4 3of8/512/offset",      4, 0, 3, 8);
        single("R2 code7 ones/1024/twos",    7, 1, 1, 1);
        single("R4 code3 5of8/32",           0, 3, 5, 8);

        // R7 continuous: three results, then stop
        for (int k = 0; k < 3; k++) begin
            e.val = exp_val(0, 5, 8); e.at = (3 + k) * 32; e.tag = "R7 continuous";
            q.push_back(e);
        end
        start(0, 0, 1'b1);
        run(5, 8, 96 + 64);
        bus_write(2'd0, 8'h02);
        bus_read(2'd1, v); chk("R7 busy after stop", v, 0);
        run(5, 8, 64);
        chk("R7 no result after stop", q.size(), 0);
        bus_read(2'd1, v); chk("R7 flag after stop", v, 0);

        // R10 ignored restart while busy
        start(0, 0, 1'b1);
        bus_write(2'd0, 8'hA9);
        bus_read(2'd0, v); chk("R10 config unchanged", v, 32'h04);
        bus_read(2'd1, v); chk("R10 still busy", v, 1);

        // R9 flag clearing paths
        auto_read = 1'b0;
        run(1, 1, 96);
        chk("R8 irq on first result", int'(irq), 1);
        bus_write(2'd1, 8'h02);
        chk("R9 status write clears", int'(irq), 0);
        run(1, 1, 31);
        chk("R9 no flag mid period", int'(irq), 0);
        tick(1'b1, 1'b1);
        chk("R9 set wins over clear", int'(irq), 1);
        bus_read(2'd2, v); chk("R9 result value", v, 32'hFFFF);
        chk("R9 read clears", int'(irq), 0);
        bus_write(2'd0, 8'h02);
        bus_read(2'd1, v); chk("R7 idle after stop", v, 0);
        auto_read = 1'b1;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule